// File: doc/BRIEF.md
# UART FIFO Threshold and DMA Request Controller

This block tracks the fill state of the receive and transmit FIFOs of a UART and turns it into interrupt and DMA request lines. Each FIFO is modelled as an occupancy counter, 64 entries deep by default, driven by push and pop strobes. A small byte-wide register interface holds the thresholds and mode bits. The controller derives a receive-data interrupt, a receive-timeout interrupt, a transmit interrupt and one DMA request line for each direction. The current transmit occupancy is exposed as a port.

Each direction has its own trigger level. It is built from a two-bit field in the FIFO control register and a four-bit field in the trigger-level register. A granularity bit in the supplementary control register chooses between a trigger fine to one byte and a coarse trigger. The supplementary register also holds three more controls. The first is a transmit-empty mode, in which the transmit interrupt ignores its trigger. The second is a DMA-mode field. The third is a bit that makes that field take priority over the FIFO-control DMA select. A write that sets the DMA-mode field and switches over to it in the same step is refused.

Top module: `uart_fifo_trig`

## Requirements
- R1: After reset both occupancies read 0. Each push adds one entry, each pop removes one, and a push and a pop in the same cycle leave the count unchanged. A pop from an empty FIFO has no effect.
- R2: A push into a full FIFO (count 64) that is not paired with a pop is dropped and sets that FIFO's overrun flag. The flag stays set until the FIFO is cleared.
- R3: Register 0 (FIFO control) is written with bit 1 to empty the receive FIFO and with bit 2 to empty the transmit FIFO. The emptying also clears that FIFO's overrun flag and takes precedence over a push or pop in the same cycle.
- R4: Register 2 (supplementary control) holds the fine-granularity bits: bit 7 for receive and bit 6 for transmit. With fine granularity, the trigger is the nibble from register 1 (trigger level; receive in bits 7:4, transmit in bits 3:0) times 4, plus the two-bit field from register 0 (receive in bits 7:6, transmit in bits 5:4). A result of 0 is raised to 1.
- R5: With coarse granularity, a nonzero nibble gives a trigger of nibble times 4. A zero nibble gives a trigger chosen by the two-bit field: receive 8, 16, 56, 60 and transmit 8, 16, 32, 56 for codes 0 to 3.
- R6: rx_irq is high when rx_int_en is high and the receive count is at least the receive trigger.
- R7: While the receive count is nonzero and below the receive trigger, each bit_tick advances a timeout counter. After 40 ticks (4 characters of 10 bits), the receive timeout flag sets, and rx_timeout_irq equals it gated by rx_int_en. Any push or pop restarts the counter. A pop or a receive clear drops the flag.
- R8: With transmit-empty mode off, tx_irq is high when tx_int_en is high and the free transmit room (64 minus tx_level) is at least the transmit trigger.
- R9: With register 2 bit 3 set (transmit-empty mode), tx_irq is high only when tx_int_en is high and tx_level is 0.
- R10: DMA requests are raised only in DMA mode 1. In that mode, tx_dma_req is high when the free transmit room is at least the transmit trigger, and rx_dma_req is high when the receive count is at least the receive trigger.
- R11: Register 2 bit 0 set makes bits 2:1 the DMA mode. If bit 0 was clear before, a write that sets bit 0 together with a nonzero mode field stores the mode field as 0. The mode takes effect only through a later write while bit 0 is already set.
- R12: While register 2 bit 0 is clear, register 0 bit 3 set selects DMA mode 1 and clear selects no DMA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 FIFO control, 1 trigger level, 2 supplementary control |
| cfg_wdata | input | 8 | Register write data |
| rx_push | input | 1 | Byte written into the receive FIFO |
| rx_pop | input | 1 | Byte read from the receive FIFO |
| tx_push | input | 1 | Byte written into the transmit FIFO |
| tx_pop | input | 1 | Byte taken by the transmitter |
| bit_tick | input | 1 | One pulse per bit time on the line |
| rx_int_en | input | 1 | Receive interrupt enable |
| tx_int_en | input | 1 | Transmit interrupt enable |
| rx_count | output | 7 | Receive FIFO occupancy |
| tx_level | output | 7 | Transmit FIFO occupancy |
| rx_overrun | output | 1 | Receive push dropped since last clear |
| tx_overrun | output | 1 | Transmit push dropped since last clear |
| rx_irq | output | 1 | Receive trigger reached |
| rx_timeout_irq | output | 1 | Receive timeout |
| tx_irq | output | 1 | Transmit interrupt |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
The assertions assume that the strobes are synchronous and free of X after reset. They also assume that the trigger fields never program a level above the FIFO depth, which holds for the default depth of 64 because the largest field value is 63. The stimulus drives inputs shortly after each rising edge. It writes registers only through single-cycle strobes and uses random push and pop rates that reach both the full and the empty boundary. The DMA guard checks rely on the DMA-mode control bit being clear before the refused write, and the bench sets up that order.

// File: rtl/uft_pkg.sv
// Package: register addresses and bit positions of the FIFO trigger controller.
// Assumes an 8-bit register interface with a 2-bit address.
package uft_pkg;
    localparam logic [1:0] ADDR_FCTL = 2'd0;  // FIFO control
    localparam logic [1:0] ADDR_TLVL = 2'd1;  // trigger level nibbles
    localparam logic [1:0] ADDR_SCTL = 2'd2;  // supplementary control

    localparam int FCTL_CLR_RX  = 1;
    localparam int FCTL_CLR_TX  = 2;
    localparam int FCTL_DMA_SEL = 3;
    localparam int FCTL_TX_LO   = 4;
    localparam int FCTL_RX_LO   = 6;

    localparam int SCTL_MODE_CTL = 0;
    localparam int SCTL_MODE_LSB = 1;
    localparam int SCTL_TX_EMPTY = 3;
    localparam int SCTL_TX_FINE  = 6;
    localparam int SCTL_RX_FINE  = 7;

    localparam logic [1:0] DMA_MODE_ONE = 2'd1;
endpackage

// File: rtl/uft_occ.sv
// Occupancy counter standing in for one FIFO.
// Clear wins over push/pop; a push into a full FIFO without a pop is dropped
// and sets a sticky overrun flag; a pop on empty is ignored.
module uft_occ #(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    output logic [CW-1:0] count,
    output logic          overrun
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic do_pop, do_push;

    // Qualify strobes against the current fill state.
    always_comb begin
        do_pop  = pop && (count != '0);
        do_push = push && ((count != FULL) || do_pop);
    end

    // Count and overrun state.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            count <= count + CW'(do_push) - CW'(do_pop);
            if (push && !do_push) overrun <= 1'b1;
        end
    end
endmodule

// File: rtl/uft_trig.sv
// Trigger level for one direction, from a fine/coarse select, a nibble and a
// two-bit low field. IS_TX picks the coarse table. Result is never zero.
module uft_trig #(
    parameter int CW    = 7,
    parameter bit IS_TX = 1'b0
) (
    input  logic          fine,
    input  logic [3:0]    nib,
    input  logic [1:0]    lo,
    output logic [CW-1:0] trig
);
    logic [5:0] coarse;

    // Coarse table, chosen per direction.
    generate
        if (IS_TX) begin : g_tx_tab
            always_comb begin
                case (lo)
                    2'd0:    coarse = 6'd8;
                    2'd1:    coarse = 6'd16;
                    2'd2:    coarse = 6'd32;
                    default: coarse = 6'd56;
                endcase
            end
        end else begin : g_rx_tab
            always_comb begin
                case (lo)
                    2'd0:    coarse = 6'd8;
                    2'd1:    coarse = 6'd16;
                    2'd2:    coarse = 6'd56;
                    default: coarse = 6'd60;
                endcase
            end
        end
    endgenerate

    // Combine nibble, low field and granularity.
    always_comb begin
        if (fine)
            trig = ({nib, lo} == 6'd0) ? CW'(1) : CW'({nib, lo});
        else if (nib != 4'd0)
            trig = CW'({nib, 2'b00});
        else
            trig = CW'(coarse);
    end
endmodule

// File: rtl/uft_timeout.sv
// Receive idle timeout: counts line bit ticks while the receive FIFO holds
// data below its trigger. Any push or pop restarts the count; a pop or
// clear drops the flag.
module uft_timeout #(
    parameter int CW        = 7,
    parameter int CHAR_BITS = 10,
    parameter int CHARS     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic          tick,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] trig,
    output logic          flag
);
    localparam int LIMIT = CHAR_BITS * CHARS;
    localparam int TW    = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LIM = TW'(LIMIT);

    logic [TW-1:0] ticks;
    logic          active;

    // Counting window: data present but below trigger.
    always_comb active = (count != '0) && (count < trig);

    // Tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || push || pop)
            ticks <= '0;
        else if (tick && active && ticks != LIM)
            ticks <= ticks + TW'(1);
    end

    // Sticky timeout flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || pop)
            flag <= 1'b0;
        else if (!push && tick && active && ticks == LIM - TW'(1))
            flag <= 1'b1;
    end
endmodule

// File: rtl/uart_fifo_trig.sv
// Top: register file, two occupancy counters, trigger builders, receive
// timeout and the interrupt / DMA request decode.
// Assumes single-cycle write strobes and trigger fields not above DEPTH.
module uart_fifo_trig #(
    parameter int DEPTH         = 64,
    parameter int CHAR_BITS     = 10,
    parameter int TIMEOUT_CHARS = 4,
    localparam int CW           = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [7:0]    cfg_wdata,
    input  logic          rx_push,
    input  logic          rx_pop,
    input  logic          tx_push,
    input  logic          tx_pop,
    input  logic          bit_tick,
    input  logic          rx_int_en,
    input  logic          tx_int_en,
    output logic [CW-1:0] rx_count,
    output logic [CW-1:0] tx_level,
    output logic          rx_overrun,
    output logic          tx_overrun,
    output logic          rx_irq,
    output logic          rx_timeout_irq,
    output logic          tx_irq,
    output logic          rx_dma_req,
    output logic          tx_dma_req
);
    import uft_pkg::*;

    // Stored register fields.
    logic       fc_dma_sel;
    logic [1:0] fc_tx_lo, fc_rx_lo;
    logic [3:0] tl_tx, tl_rx;
    logic       sc_rx_fine, sc_tx_fine, sc_tx_empty, sc_ctl;
    logic [1:0] sc_mode;

    logic          wr_fctl, wr_tlvl, wr_sctl;
    logic          rx_clr, tx_clr;
    logic [CW-1:0] rx_trig, tx_trig, tx_room;
    logic [1:0]    dma_mode;
    logic          dma_on, to_flag, refuse_mode;

    // Write decode and clear strobes.
    always_comb begin
        wr_fctl     = cfg_we && cfg_addr == ADDR_FCTL;
        wr_tlvl     = cfg_we && cfg_addr == ADDR_TLVL;
        wr_sctl     = cfg_we && cfg_addr == ADDR_SCTL;
        rx_clr      = wr_fctl && cfg_wdata[FCTL_CLR_RX];
        tx_clr      = wr_fctl && cfg_wdata[FCTL_CLR_TX];
        refuse_mode = cfg_wdata[SCTL_MODE_CTL] && !sc_ctl
                      && (cfg_wdata[SCTL_MODE_LSB +: 2] != 2'd0);
    end

    // Register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fc_dma_sel <= 1'b0; fc_tx_lo <= '0; fc_rx_lo <= '0;
            tl_tx <= '0; tl_rx <= '0;
            sc_rx_fine <= 1'b0; sc_tx_fine <= 1'b0; sc_tx_empty <= 1'b0;
            sc_ctl <= 1'b0; sc_mode <= '0;
        end else begin
            if (wr_fctl) begin
                fc_dma_sel <= cfg_wdata[FCTL_DMA_SEL];
                fc_tx_lo   <= cfg_wdata[FCTL_TX_LO +: 2];
                fc_rx_lo   <= cfg_wdata[FCTL_RX_LO +: 2];
            end
            if (wr_tlvl) begin
                tl_tx <= cfg_wdata[3:0];
                tl_rx <= cfg_wdata[7:4];
            end
            if (wr_sctl) begin
                sc_rx_fine  <= cfg_wdata[SCTL_RX_FINE];
                sc_tx_fine  <= cfg_wdata[SCTL_TX_FINE];
                sc_tx_empty <= cfg_wdata[SCTL_TX_EMPTY];
                sc_ctl      <= cfg_wdata[SCTL_MODE_CTL];
                sc_mode     <= refuse_mode ? 2'd0 : cfg_wdata[SCTL_MODE_LSB +: 2];
            end
        end
    end

    uft_occ #(.DEPTH(DEPTH), .CW(CW)) u_rx_occ (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push), .pop(rx_pop),
        .count(rx_count), .overrun(rx_overrun));

    uft_occ #(.DEPTH(DEPTH), .CW(CW)) u_tx_occ (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push), .pop(tx_pop),
        .count(tx_level), .overrun(tx_overrun));

    uft_trig #(.CW(CW), .IS_TX(1'b0)) u_rx_trig (
        .fine(sc_rx_fine), .nib(tl_rx), .lo(fc_rx_lo), .trig(rx_trig));

    uft_trig #(.CW(CW), .IS_TX(1'b1)) u_tx_trig (
        .fine(sc_tx_fine), .nib(tl_tx), .lo(fc_tx_lo), .trig(tx_trig));

    uft_timeout #(.CW(CW), .CHAR_BITS(CHAR_BITS), .CHARS(TIMEOUT_CHARS)) u_rx_to (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push), .pop(rx_pop),
        .tick(bit_tick), .count(rx_count), .trig(rx_trig), .flag(to_flag));

    // Interrupt and DMA request decode.
    always_comb begin
        tx_room        = CW'(DEPTH) - tx_level;
        dma_mode       = sc_ctl ? sc_mode : {1'b0, fc_dma_sel};
        dma_on         = dma_mode == DMA_MODE_ONE;
        rx_irq         = rx_int_en && (rx_count >= rx_trig);
        rx_timeout_irq = rx_int_en && to_flag;
        tx_irq         = tx_int_en && (sc_tx_empty ? (tx_level == '0)
                                                   : (tx_room >= tx_trig));
        rx_dma_req     = dma_on && (rx_count >= rx_trig);
        tx_dma_req     = dma_on && (tx_room >= tx_trig);
    end
endmodule

// File: rtl/uart_fifo_trig_chk.sv
// Checker bound to uart_fifo_trig: temporal properties across its pieces.
// Assumes synchronous, X-free inputs after reset.
module uart_fifo_trig_chk #(
    parameter int DEPTH = 64,
    parameter int CW    = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] rx_count,
    input logic [CW-1:0] tx_level,
    input logic          rx_overrun,
    input logic          rx_clr,
    input logic          tx_clr,
    input logic          rx_timeout_irq,
    input logic          tx_irq,
    input logic          sc_tx_empty,
    input logic          dma_on,
    input logic          rx_dma_req,
    input logic          tx_dma_req,
    input logic          refuse_mode,
    input logic          wr_sctl
);
    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count <= CW'(DEPTH)) && (tx_level <= CW'(DEPTH)));

    assert_overrun_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !rx_clr) |=> rx_overrun);

    assert_clear_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_clr || tx_clr) |=> ((!$past(rx_clr) || rx_count == '0)
                                && (!$past(tx_clr) || tx_level == '0)));

    assert_timeout_has_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_timeout_irq |-> rx_count != '0);

    assert_empty_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && sc_tx_empty) |-> tx_level == '0);

    assert_dma_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_on |-> (!rx_dma_req && !tx_dma_req));

    assert_guard_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sctl && refuse_mode) |=> (!rx_dma_req && !tx_dma_req));
endmodule

bind uart_fifo_trig uart_fifo_trig_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_level(tx_level),
    .rx_overrun(rx_overrun), .rx_clr(rx_clr), .tx_clr(tx_clr),
    .rx_timeout_irq(rx_timeout_irq), .tx_irq(tx_irq), .sc_tx_empty(sc_tx_empty),
    .dma_on(dma_on), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
    .refuse_mode(refuse_mode), .wr_sctl(wr_sctl));

// File: tb/uart_fifo_trig_test.sv
// Bench: behavioural reference model compared on every clock, plus directed
// checks of each requirement.
module uart_fifo_trig_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_addr = 2'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0, bit_tick = 0;
    logic rx_int_en = 0, tx_int_en = 0;
    logic [6:0] rx_count, tx_level;
    logic rx_overrun, tx_overrun, rx_irq, rx_timeout_irq, tx_irq, rx_dma_req, tx_dma_req;

    int n_checks = 0, n_fail = 0;
    bit started = 0, done = 0;
    string phase = "R1";

    // reference model state
    int m_rx = 0, m_tx = 0, m_rov = 0, m_tov = 0, m_fc = 0, m_tl = 0, m_sc = 0;
    int m_ticks = 0, m_tof = 0;

    uart_fifo_trig uut (.*);

    always #10 clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s (phase %s) at %0t: actual %0d expected %0d", tag, phase, $time, act, exp);
        end
    endtask

    function automatic int trig_of(bit tx);
        int nib, lo, v;
        bit fine;
        fine = tx ? m_sc[6] : m_sc[7];
        nib  = tx ? (m_tl & 15) : ((m_tl >> 4) & 15);
        lo   = tx ? ((m_fc >> 4) & 3) : ((m_fc >> 6) & 3);
        if (fine) begin
            v = nib * 4 + lo;
            if (v == 0) v = 1;
        end else if (nib != 0) v = nib * 4;
        else if (tx) v = (lo == 0) ? 8 : (lo == 1) ? 16 : (lo == 2) ? 32 : 56;
        else         v = (lo == 0) ? 8 : (lo == 1) ? 16 : (lo == 2) ? 56 : 60;
        return v;
    endfunction

    function automatic bit dma_mode1();
        int mode;
        mode = m_sc[0] ? ((m_sc >> 1) & 3) : (m_fc[3] ? 1 : 0);
        return mode == 1;
    endfunction

    // Reference model update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_rx = 0; m_tx = 0; m_rov = 0; m_tov = 0; m_fc = 0; m_tl = 0; m_sc = 0;
            m_ticks = 0; m_tof = 0;
        end else begin
            bit rclr, tclr, rp, tp;
            int rt;
            rclr = cfg_we && cfg_addr == 0 && cfg_wdata[1];
            tclr = cfg_we && cfg_addr == 0 && cfg_wdata[2];
            rt = trig_of(0);
            if (rclr || rx_push || rx_pop) m_ticks = 0;
            else if (bit_tick && m_rx > 0 && m_rx < rt && m_ticks < 40) begin
                m_ticks++;
                if (m_ticks == 40) m_tof = 1;
            end
            if (rclr || rx_pop) m_tof = 0;
            if (rclr) begin m_rx = 0; m_rov = 0; end
            else begin
                rp = rx_pop && m_rx > 0;
                if (rx_push && (m_rx < 64 || rp)) m_rx++;
                else if (rx_push) m_rov = 1;
                if (rp) m_rx--;
            end
            if (tclr) begin m_tx = 0; m_tov = 0; end
            else begin
                tp = tx_pop && m_tx > 0;
                if (tx_push && (m_tx < 64 || tp)) m_tx++;
                else if (tx_push) m_tov = 1;
                if (tp) m_tx--;
            end
            if (cfg_we) begin
                if (cfg_addr == 0) m_fc = cfg_wdata;
                else if (cfg_addr == 1) m_tl = cfg_wdata;
                else if (cfg_addr == 2) begin
                    if (cfg_wdata[0] && (cfg_wdata[2:1] != 0) && !m_sc[0])
                        m_sc = cfg_wdata & 8'hF9;
                    else m_sc = cfg_wdata;
                end
            end
        end
    end

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (started && rst_n && !done) begin
            int rt, tt, room;
            rt = trig_of(0); tt = trig_of(1); room = 64 - m_tx;
            chk("R1 rx_count", rx_count, m_rx);
            chk("R1 tx_level", tx_level, m_tx);
            chk("R2 rx_overrun", rx_overrun, m_rov);
            chk("R2 tx_overrun", tx_overrun, m_tov);
            chk("R6 rx_irq", rx_irq, rx_int_en && m_rx >= rt);
            chk("R7 rx_timeout_irq", rx_timeout_irq, rx_int_en && m_tof);
            chk("R8 tx_irq", tx_irq, tx_int_en && (m_sc[3] ? (m_tx == 0) : (room >= tt)));
            chk("R10 rx_dma_req", rx_dma_req, dma_mode1() && m_rx >= rt);
            chk("R10 tx_dma_req", tx_dma_req, dma_mode1() && room >= tt);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #2; cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #2; cfg_we = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic push_rx(int n);
        repeat (n) begin @(posedge clk); #2; rx_push = 1; end
        @(posedge clk); #2; rx_push = 0;
    endtask

    task automatic pop_rx(int n);
        repeat (n) begin @(posedge clk); #2; rx_pop = 1; end
        @(posedge clk); #2; rx_pop = 0;
    endtask

    task automatic push_tx(int n);
        repeat (n) begin @(posedge clk); #2; tx_push = 1; end
        @(posedge clk); #2; tx_push = 0;
    endtask

    task automatic pop_tx(int n);
        repeat (n) begin @(posedge clk); #2; tx_pop = 1; end
        @(posedge clk); #2; tx_pop = 0;
    endtask

    task automatic traffic(int n, int prx, int qrx, int ptx, int qtx);
        repeat (n) begin
            @(posedge clk); #2;
            rx_push  = ($urandom % 100) < prx;
            rx_pop   = ($urandom % 100) < qrx;
            tx_push  = ($urandom % 100) < ptx;
            tx_pop   = ($urandom % 100) < qtx;
            bit_tick = ($urandom % 100) < 60;
        end
        @(posedge clk); #2;
        rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0; bit_tick = 0;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired in phase %s", phase);
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Directed and random stimulus.
    initial begin
        repeat (3) @(posedge clk);
        #2; rst_n = 1; started = 1;
        #1;
        phase = "R1";
        chk("R1 reset rx_count", rx_count, 0);
        chk("R1 reset tx_level", tx_level, 0);
        chk("R1 reset tx_dma_req", tx_dma_req, 0);
        pop_rx(2);
        chk("R1 pop on empty ignored", rx_count, 0);

        phase = "R12";
        wr(0, 8'h08); #1;
        chk("R12 fifo-control DMA select", tx_dma_req, 1);
        chk("R12 rx below trigger", rx_dma_req, 0);
        wr(0, 8'h00);

        phase = "R11";
        wr(2, 8'h03); #1;
        chk("R11 combined write refused", tx_dma_req, 0);
        wr(2, 8'h01); wr(2, 8'h03); #1;
        chk("R10 two-step enable tx_dma_req", tx_dma_req, 1);
        push_rx(8); #1;
        chk("R10 rx_dma_req at trigger 8", rx_dma_req, 1);
        wr(0, 8'h02); wr(2, 8'h00);

        phase = "R2";
        push_rx(65); #1;
        chk("R2 count saturates at 64", rx_count, 64);
        chk("R2 overrun set", rx_overrun, 1);
        phase = "R3";
        wr(0, 8'h02); #1;
        chk("R3 rx emptied", rx_count, 0);
        chk("R3 overrun cleared", rx_overrun, 0);

        phase = "R8";
        tx_int_en = 1;
        push_tx(57); #1;
        chk("R8 room 7 below trigger 8", tx_irq, 0);
        pop_tx(1); #1;
        chk("R8 room 8 meets trigger", tx_irq, 1);
        phase = "R3";
        wr(0, 8'h04); #1;
        chk("R3 tx emptied", tx_level, 0);

        phase = "R9";
        wr(2, 8'h08);
        push_tx(1); #1;
        chk("R9 one byte blocks empty-mode irq", tx_irq, 0);
        pop_tx(1); #1;
        chk("R9 empty raises irq", tx_irq, 1);
        wr(2, 8'h00);

        phase = "R5";
        rx_int_en = 1;
        wr(0, 8'h80);
        push_rx(55); #1;
        chk("R5 coarse 56 not reached", rx_irq, 0);
        push_rx(1); #1;
        chk("R5 coarse 56 reached", rx_irq, 1);
        wr(1, 8'h30); wr(0, 8'h02); push_rx(11); #1;
        chk("R5 nibble 3 gives 12, below", rx_irq, 0);
        push_rx(1); #1;
        chk("R5 nibble 3 gives 12, reached", rx_irq, 1);
        wr(0, 8'h02); wr(1, 8'h00);

        phase = "R4";
        wr(2, 8'h80); wr(1, 8'h20); wr(0, 8'hC0);
        push_rx(10); #1;
        chk("R4 fine trigger 11 not reached", rx_irq, 0);
        push_rx(1); #1;
        chk("R6 fine trigger 11 reached", rx_irq, 1);
        wr(1, 8'h00); wr(0, 8'h02);
        push_rx(1); #1;
        chk("R4 zero trigger raised to 1", rx_irq, 1);
        wr(0, 8'h02); wr(2, 8'h00);

        phase = "R7";
        push_rx(3);
        bit_tick = 1;
        idle(38); #1;
        chk("R7 no timeout after 38 ticks", rx_timeout_irq, 0);
        idle(3); #1;
        chk("R7 timeout after 40 ticks", rx_timeout_irq, 1);
        pop_rx(1); #1;
        chk("R7 pop clears timeout", rx_timeout_irq, 0);
        bit_tick = 0;
        wr(0, 8'h02);

        for (int k = 0; k < 6; k++) begin
            phase = "R4";
            wr(1, 8'($urandom));
            wr(0, 8'($urandom) & 8'hF9);
            wr(2, 8'($urandom) & 8'hC8);
            if (k % 2 == 1) begin wr(2, 8'h01 | (8'($urandom) & 8'hC8)); wr(2, 8'h03); end
            rx_int_en = ($urandom % 2) == 1;
            tx_int_en = ($urandom % 2) == 1;
            phase = "R10";
            traffic(400, 55, 45, 40, 50);
            traffic(200, 20, 70, 70, 20);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule